// File: doc/BRIEF.md
# Eye Scanner Alignment Checker

This block confirms that a receiver's eye-scan sampler is aligned and corrects it when it is not. A start pulse begins the sequence. The block first asks an external point-measurement engine for one short measurement taken at the centre of the eye: zero vertical offset, zero horizontal offset and a prescale code of 5. If the engine reports no errors, the sampler is aligned and the block reports that.

If the error count is nonzero, the block runs a realignment. It writes the correction code 0x880 into the 12-bit horizontal offset field of configuration register 0x4F. This is a read-modify-write that keeps the low four bits of the register. The block then raises the scan reset line and holds it for a set number of cycles. While reset is high, it writes the release code 0x800 into the same field, again by read-modify-write. Only after that write completes does it drop scan reset.

After each realignment the block repeats the measurement. It declares alignment as soon as a measurement returns zero errors. If the error count is still nonzero after a configurable number of realignment attempts, it gives up and reports failure. The block uses a simple request/acknowledge register port and a request/done link to the measurement engine. It does not program any data masks.

Top module: `esa_align_ctrl`

## Requirements
- R1: After reset, all of these outputs are 0: `meas_req_o`, `reg_en_o`, `scan_rst_o`, `busy_o`, `aligned_o` and `failed_o`.
- R2: Each check raises `meas_req_o` with `meas_vofs_o` = 0, `meas_hofs_o` = 0 and `meas_prescale_o` = 5. The request stays high until the cycle in which `meas_done_i` is 1.
- R3: A check whose `meas_errs_i` is 0 ends the run. The block sets `aligned_o` = 1 and `busy_o` = 0, and makes no further register access.
- R4: A check with nonzero errors starts a realignment, counted as one attempt. The realignment first reads register 0x4F and then writes it back. The write data has bits [15:4] = 0x880, and bits [3:0] equal to bits [3:0] of the value just read.
- R5: `scan_rst_o` rises only after the first write of the realignment completes. It stays high for at least RST_HOLD cycles before the second read-modify-write of 0x4F begins. That second write has bits [15:4] = 0x800, with bits [3:0] preserved. `scan_rst_o` falls only after this write completes, and it is never high while `meas_req_o` is high.
- R6: Every realignment is followed by a new check. A run with k failing checks followed by a passing one (k ≤ MAX_TRIES) makes exactly k realignments and k+1 checks, and ends aligned.
- R7: If the check after the MAX_TRIES-th realignment still reports errors, the block sets `failed_o` = 1 and `busy_o` = 0. That run has made MAX_TRIES+1 checks and 2·MAX_TRIES writes. `aligned_o` and `failed_o` are never both 1.
- R8: A `start_i` pulse while `busy_o` = 1 is ignored: the run's number of checks and writes does not change.
- R9: A `start_i` pulse while idle clears `aligned_o` and `failed_o`, and sets `busy_o` = 1 in the next cycle.
- R10: Once a register request is raised (`reg_en_o` = 1), `reg_we_o`, `reg_addr_o` and `reg_wdata_o` stay steady until the cycle in which `reg_rdy_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a check/realign run when idle |
| meas_req_o | output | 1 | Measurement request to the point engine |
| meas_vofs_o | output | VOFS_W | Vertical offset for the measurement (always 0) |
| meas_hofs_o | output | HOFS_W | Horizontal offset for the measurement (always 0) |
| meas_prescale_o | output | PRE_W | Prescale code for the measurement |
| meas_done_i | input | 1 | Measurement complete, error count valid |
| meas_errs_i | input | ERR_W | Error count of the finished measurement |
| reg_en_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | REG_AW | Register address |
| reg_wdata_o | output | REG_DW | Write data |
| reg_rdy_i | input | 1 | Access complete; read data valid |
| reg_rdata_i | input | REG_DW | Read data |
| scan_rst_o | output | 1 | Eye-scan reset line |
| busy_o | output | 1 | A run is in progress |
| aligned_o | output | 1 | Last run ended with a zero-error check |
| failed_o | output | 1 | Last run exhausted its attempts |

## Verification
The bench targets four edges:
- The attempt limit. Runs need exactly MAX_TRIES realignments, and then one more than that. A miscounted limit ends aligned where it should fail, or fails one attempt early.
- Register contents. The register's low nibble is randomized between runs. A read-modify-write that merges at the wrong bit position, or drops the read value, corrupts those bits.
- Sequence order. The bench checks where each write falls relative to the scan reset, and how long reset is held before the release write. This catches a reset raised too early, released before the second write, or overlapping a measurement.
- Spurious starts. A start pulse in the middle of a run must not restart the attempt count. A fresh start after a failure must clear the old status.

// File: rtl/esa_align_pkg.sv
package esa_align_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SET,
    ST_HOLD,
    ST_CLEAR
  } seq_state_t;

  typedef enum logic [1:0] {
    RMW_IDLE,
    RMW_READ,
    RMW_WRITE
  } rmw_state_t;

endpackage

// File: rtl/esa_meas_port.sv
module esa_meas_port #(
  parameter int VOFS_W   = 11,
  parameter int HOFS_W   = 12,
  parameter int PRE_W    = 5,
  parameter int ERR_W    = 16,
  parameter int PRESCALE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              meas_done_i,
  input  logic [ERR_W-1:0]  meas_errs_i,
  output logic              meas_req_o,
  output logic [VOFS_W-1:0] meas_vofs_o,
  output logic [HOFS_W-1:0] meas_hofs_o,
  output logic [PRE_W-1:0]  meas_prescale_o,
  output logic              fire,
  output logic              clean
);

  function automatic logic no_errors(input logic [ERR_W-1:0] cnt);
    return cnt == '0;
  endfunction

  assign meas_req_o      = active;
  assign meas_vofs_o     = '0;
  assign meas_hofs_o     = '0;
  assign meas_prescale_o = PRE_W'(PRESCALE);
  assign fire            = active && meas_done_i;
  assign clean           = fire && no_errors(meas_errs_i);

  // R2: request held until the engine answers
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req_o && !meas_done_i) |=> meas_req_o);

endmodule

// File: rtl/esa_reg_rmw.sv
module esa_reg_rmw
  import esa_align_pkg::*;
#(
  parameter int REG_AW    = 10,
  parameter int REG_DW    = 16,
  parameter int HOFS_W    = 12,
  parameter int FIELD_LSB = 4,
  parameter int ADDR      = 'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [HOFS_W-1:0] code,
  input  logic              reg_rdy_i,
  input  logic [REG_DW-1:0] reg_rdata_i,
  output logic              reg_en_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [REG_DW-1:0] reg_wdata_o,
  output logic              rd_done,
  output logic              done
);

  localparam logic [REG_DW-1:0] FIELD_MASK =
    REG_DW'(((1 << HOFS_W) - 1) << FIELD_LSB);

  function automatic logic [REG_DW-1:0] merge_field(
    input logic [REG_DW-1:0] old_word,
    input logic [HOFS_W-1:0] fld);
    return (old_word & ~FIELD_MASK) | ((REG_DW'(fld) << FIELD_LSB) & FIELD_MASK);
  endfunction

  rmw_state_t        st_q;
  logic [HOFS_W-1:0] code_q;
  logic [REG_DW-1:0] wdata_q;

  assign reg_en_o    = (st_q != RMW_IDLE);
  assign reg_we_o    = (st_q == RMW_WRITE);
  assign reg_addr_o  = REG_AW'(ADDR);
  assign reg_wdata_o = wdata_q;
  assign rd_done     = (st_q == RMW_READ) && reg_rdy_i;
  assign done        = (st_q == RMW_WRITE) && reg_rdy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RMW_IDLE;
      code_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        RMW_IDLE: if (go) begin
          code_q <= code;
          st_q   <= RMW_READ;
        end
        RMW_READ: if (reg_rdy_i) begin
          wdata_q <= merge_field(reg_rdata_i, code_q);
          st_q    <= RMW_WRITE;
        end
        RMW_WRITE: if (reg_rdy_i) st_q <= RMW_IDLE;
        default: st_q <= RMW_IDLE;
      endcase
    end
  end

  // R10: request fields steady while waiting for the port
  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en_o && !reg_rdy_i) |=> (reg_en_o && $stable(reg_we_o) &&
      $stable(reg_addr_o) && $stable(reg_wdata_o)));

  // R4: a completed read is followed directly by the write to the same address
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (reg_en_o && reg_we_o && reg_addr_o == $past(reg_addr_o)));

endmodule

// File: rtl/esa_try_counter.sv
module esa_try_counter #(
  parameter int MAX_TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic exhausted
);

  localparam int CNT_W = $clog2(MAX_TRIES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign exhausted = (cnt_q >= CNT_W'(MAX_TRIES));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (inc && !exhausted) cnt_q <= cnt_q + 1'b1;
  end

  // R7: attempts never exceed the configured limit
  assert_try_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_TRIES));

endmodule

// File: rtl/esa_align_ctrl.sv
module esa_align_ctrl
  import esa_align_pkg::*;
#(
  parameter int REG_AW    = 10,
  parameter int REG_DW    = 16,
  parameter int VOFS_W    = 11,
  parameter int HOFS_W    = 12,
  parameter int PRE_W     = 5,
  parameter int ERR_W     = 16,
  parameter int FIELD_LSB = 4,
  parameter int HOFS_ADDR = 'h4F,
  parameter int PRESCALE  = 5,
  parameter int CODE_SET  = 'h880,
  parameter int CODE_REL  = 'h800,
  parameter int RST_HOLD  = 4,
  parameter int MAX_TRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              meas_req_o,
  output logic [VOFS_W-1:0] meas_vofs_o,
  output logic [HOFS_W-1:0] meas_hofs_o,
  output logic [PRE_W-1:0]  meas_prescale_o,
  input  logic              meas_done_i,
  input  logic [ERR_W-1:0]  meas_errs_i,
  output logic              reg_en_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [REG_DW-1:0] reg_wdata_o,
  input  logic              reg_rdy_i,
  input  logic [REG_DW-1:0] reg_rdata_i,
  output logic              scan_rst_o,
  output logic              busy_o,
  output logic              aligned_o,
  output logic              failed_o
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  seq_state_t        st_q;
  logic [HOLD_W-1:0] hold_q;
  logic              scan_rst_q, aligned_q, failed_q;

  // named internal events
  logic              ev_start, ev_meas_fire, ev_meas_clean, ev_give_up, ev_retry;
  logic              ev_hold_end, ev_rmw_rd, ev_rmw_done, tries_out;
  logic              rmw_go;
  logic [HOFS_W-1:0] rmw_code;

  assign ev_start    = (st_q == ST_IDLE) && start_i;
  assign ev_give_up  = ev_meas_fire && !ev_meas_clean && tries_out;
  assign ev_retry    = ev_meas_fire && !ev_meas_clean && !tries_out;
  assign ev_hold_end = (st_q == ST_HOLD) && (hold_q == HOLD_W'(RST_HOLD - 1));
  assign rmw_go      = ev_retry || ev_hold_end;
  assign rmw_code    = (st_q == ST_CHECK) ? HOFS_W'(CODE_SET) : HOFS_W'(CODE_REL);

  esa_meas_port #(
    .VOFS_W(VOFS_W), .HOFS_W(HOFS_W), .PRE_W(PRE_W),
    .ERR_W(ERR_W), .PRESCALE(PRESCALE)
  ) u_meas (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_CHECK),
    .meas_done_i(meas_done_i), .meas_errs_i(meas_errs_i),
    .meas_req_o(meas_req_o), .meas_vofs_o(meas_vofs_o),
    .meas_hofs_o(meas_hofs_o), .meas_prescale_o(meas_prescale_o),
    .fire(ev_meas_fire), .clean(ev_meas_clean)
  );

  esa_reg_rmw #(
    .REG_AW(REG_AW), .REG_DW(REG_DW), .HOFS_W(HOFS_W),
    .FIELD_LSB(FIELD_LSB), .ADDR(HOFS_ADDR)
  ) u_rmw (
    .clk(clk), .rst_n(rst_n), .go(rmw_go), .code(rmw_code),
    .reg_rdy_i(reg_rdy_i), .reg_rdata_i(reg_rdata_i),
    .reg_en_o(reg_en_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .rd_done(ev_rmw_rd), .done(ev_rmw_done)
  );

  esa_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .inc(ev_retry),
    .exhausted(tries_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      hold_q     <= '0;
      scan_rst_q <= 1'b0;
      aligned_q  <= 1'b0;
      failed_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (ev_start) begin
          aligned_q <= 1'b0;
          failed_q  <= 1'b0;
          st_q      <= ST_CHECK;
        end
        ST_CHECK: begin
          if (ev_meas_clean) begin
            aligned_q <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (ev_give_up) begin
            failed_q <= 1'b1;
            st_q     <= ST_IDLE;
          end else if (ev_retry) begin
            st_q <= ST_SET;
          end
        end
        ST_SET: if (ev_rmw_done) begin
          scan_rst_q <= 1'b1;
          hold_q     <= '0;
          st_q       <= ST_HOLD;
        end
        ST_HOLD: begin
          if (ev_hold_end) st_q <= ST_CLEAR;
          else             hold_q <= hold_q + 1'b1;
        end
        ST_CLEAR: if (ev_rmw_done) begin
          scan_rst_q <= 1'b0;
          st_q       <= ST_CHECK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_rst_o = scan_rst_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign aligned_o  = aligned_q;
  assign failed_o   = failed_q;

  // R5: reset and measurement never overlap
  assert_rst_no_meas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_rst_o |-> !meas_req_o);

  // R5: reset only rises on completion of the first write
  assert_rst_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_rst_o && !ev_rmw_done) |=> !scan_rst_o);

  // R5: reset only falls on completion of the second write
  assert_rst_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_rst_o && !ev_rmw_done) |=> scan_rst_o);

  // R7: never both aligned and failed
  assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(aligned_o && failed_o));

  // R3: a clean check ends the run aligned with the port quiet
  assert_clean_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_meas_clean |=> (aligned_o && !busy_o && !reg_en_o));

  // R8: start while busy leaves the state untouched
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && st_q == ST_HOLD && !ev_hold_end) |=> (st_q == ST_HOLD));

endmodule

// File: tb/sim_esa_align_ctrl.sv
module sim_esa_align_ctrl;

  localparam int MAXT  = 4;
  localparam int HOLD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        meas_req_o, meas_done_i = 1'b0;
  logic [10:0] meas_vofs_o;
  logic [11:0] meas_hofs_o;
  logic [4:0]  meas_prescale_o;
  logic [15:0] meas_errs_i = '0;
  logic        reg_en_o, reg_we_o, reg_rdy_i = 1'b0;
  logic [9:0]  reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i = '0;
  logic        scan_rst_o, busy_o, aligned_o, failed_o;

  always #10 clk = ~clk;

  esa_align_ctrl #(.RST_HOLD(HOLD), .MAX_TRIES(MAXT)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  int n_meas = 0, n_wr = 0, rst_hi = 0;
  int meas_lat = 0, reg_lat = 0;
  int plan_errs [0:15];
  logic [15:0] reg4f;
  bit done_flag = 0;

  function automatic logic [15:0] expect_word(input logic [15:0] old, input int fld);
    return {fld[11:0], old[3:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // responders: measurement engine and register port, driven at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (scan_rst_o) rst_hi++; else rst_hi = 0;
      if (scan_rst_o && meas_req_o) check(0, "R5 reset overlaps measurement", 1, 0);
      // measurement engine
      if (meas_done_i) meas_done_i = 1'b0;
      else if (meas_req_o) begin
        if (meas_lat == 0) begin
          check(meas_vofs_o == 0 && meas_hofs_o == 0 && meas_prescale_o == 5,
                "R2 measurement fields", {meas_vofs_o, meas_hofs_o, meas_prescale_o}, 5);
          meas_errs_i = 16'(plan_errs[n_meas < 16 ? n_meas : 15]);
          n_meas++;
          meas_done_i = 1'b1;
          meas_lat = $urandom_range(0, 6);
        end else meas_lat--;
      end
      // register port
      if (reg_rdy_i) reg_rdy_i = 1'b0;
      else if (reg_en_o) begin
        if (reg_lat == 0) begin
          check(reg_addr_o == 10'h04F, "R4 register address", reg_addr_o, 'h4F);
          if (reg_we_o) begin
            if (n_wr % 2 == 0) begin
              check(reg_wdata_o == expect_word(reg4f, 'h880), "R4 first write data",
                    reg_wdata_o, expect_word(reg4f, 'h880));
              check(!scan_rst_o, "R5 reset low at first write", scan_rst_o, 0);
            end else begin
              check(reg_wdata_o == expect_word(reg4f, 'h800), "R5 second write data",
                    reg_wdata_o, expect_word(reg4f, 'h800));
              check(scan_rst_o, "R5 reset high at second write", scan_rst_o, 1);
            end
            reg4f = reg_wdata_o;
            n_wr++;
          end else begin
            if (scan_rst_o)
              check(rst_hi >= HOLD, "R5 reset hold before release", rst_hi, HOLD);
            reg_rdata_i = reg4f;
          end
          reg_rdy_i = 1'b1;
          reg_lat = $urandom_range(0, 3);
        end else reg_lat--;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // k failing checks then a clean one; extra_start injects a start mid-run
  task automatic run_case(input int k, input bit extra_start);
    int tries;
    int guard;
    tries = (k < MAXT) ? k : MAXT;
    for (int i = 0; i < 16; i++)
      plan_errs[i] = (i < k) ? ((i % 3 == 0) ? 1 : (i % 3 == 1) ? 'hFFFF
                                : $urandom_range(1, 'hFFFF)) : 0;
    reg4f = 16'($urandom);
    n_meas = 0;
    n_wr = 0;
    pulse_start();
    check(busy_o && !aligned_o && !failed_o, "R9 start clears status",
          {busy_o, aligned_o, failed_o}, 3'b100);
    if (extra_start) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    guard = 0;
    while (busy_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    if (k <= MAXT) begin
      check(aligned_o && !failed_o && !busy_o, "R6 run ends aligned",
            {aligned_o, failed_o, busy_o}, 3'b100);
      if (k == 0) check(n_wr == 0, "R3 no register access", n_wr, 0);
    end else
      check(failed_o && !aligned_o && !busy_o, "R7 run ends failed",
            {aligned_o, failed_o, busy_o}, 3'b010);
    check(n_meas == tries + 1, extra_start ? "R8 check count" : "R6 check count",
          n_meas, tries + 1);
    check(n_wr == 2 * tries, extra_start ? "R8 write count" : "R7 write count",
          n_wr, 2 * tries);
    check(!reg_en_o && !meas_req_o && !scan_rst_o, "R7 quiet when idle",
          {reg_en_o, meas_req_o, scan_rst_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) plan_errs[i] = 0;
    reg4f = 16'h5A5A;
    repeat (4) @(negedge clk);
    check(!meas_req_o && !reg_en_o && !scan_rst_o && !busy_o && !aligned_o && !failed_o,
          "R1 reset state", {meas_req_o, reg_en_o, scan_rst_o, busy_o, aligned_o, failed_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !aligned_o && !failed_o, "R1 idle after reset",
          {busy_o, aligned_o, failed_o}, 0);
    run_case(0, 0);
    run_case(1, 0);
    run_case(MAXT, 0);
    run_case(MAXT + 1, 0);
    run_case(0, 0);          // R9: restart after failure
    run_case(3, 1);          // R8: start pulse during run
    run_case(MAXT + 2, 1);
    for (int j = 0; j < 6; j++) run_case($urandom_range(0, MAXT + 2), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

endmodule